// File: doc/BRIEF.md
# Payload Write Strobe Expander

This block sits on the receive path of a packet link, behind the header decoder, for write requests and for completions that carry data. A header-accept strobe hands it two 4-bit edge masks and a payload length in doublewords. One mask covers the opening doubleword and the other covers the closing one. The block then passes a 32-bit payload stream through, one doubleword per beat, and attaches to each beat the byte write strobe that the memory interface needs. It also attaches the zero-based doubleword index of the beat.

Strobes are not carried with the payload. The block rebuilds them from the two edge masks and the length, which covers the single-beat, opening, middle and closing cases. Completion payloads go through the same expansion, so the requester can pick out the meaningful bytes. While it walks the payload, the block adds up the enabled bytes. On the cycle the closing beat is handed off, it reports that total with a done pulse.

Top module: `wstrb_expander`

## Requirements
- R1: After reset, `hdr_ready` is 1, and `out_valid`, `in_ready`, `done` and `hdr_err` are 0.
- R2: The beat with index 0 carries `hdr_first_mask` as its strobe. Strobe bit i gates data bits [8i+7:8i], so bit 0 marks the least significant byte.
- R3: For a length of two or more, the beat with index length-1 carries `hdr_last_mask` as its strobe.
- R4: Every beat whose index lies strictly between 0 and length-1 carries strobe 4'b1111.
- R5: For a length of 1, exactly one beat is produced. Its strobe is `hdr_first_mask` whatever `hdr_last_mask` holds.
- R6: While a payload is active, `out_data` equals `in_data`, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. While idle, `out_valid` and `in_ready` are both 0.
- R7: `out_dw_idx` starts at 0 for each payload. It advances by one only on a cycle where both `out_valid` and `out_ready` are 1.
- R8: `hdr_ready` is 1 only while idle. A `hdr_load` while busy is ignored, and the block becomes idle on the cycle after the closing beat transfers.
- R9: `done` is 1 exactly on the transfer cycle of the closing beat. On that cycle, `byte_count` equals the sum of the set bits of all strobes in the payload.
- R10: A header loaded while idle with `hdr_first_mask` equal to 0 or `hdr_len_dw` equal to 0 is dropped. `hdr_err` is 1 on the following cycle only, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_load | input | 1 | Header-accept strobe |
| hdr_first_mask | input | 4 | Byte mask of the opening doubleword |
| hdr_last_mask | input | 4 | Byte mask of the closing doubleword |
| hdr_len_dw | input | LEN_W | Payload length in doublewords |
| hdr_ready | output | 1 | Idle, a header may be loaded |
| hdr_err | output | 1 | One-cycle pulse: last header was dropped |
| in_valid | input | 1 | Payload beat valid |
| in_ready | output | 1 | Payload beat accepted |
| in_data | input | 32 | Payload doubleword |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 32 | Payload doubleword passed through |
| out_strb | output | 4 | Byte write strobe of the beat |
| out_dw_idx | output | LEN_W | Zero-based doubleword index of the beat |
| byte_count | output | LEN_W+2 | Enabled bytes so far, including the current beat |
| done | output | 1 | Closing beat transferred this cycle |

## Verification
A wrong beat index shows up at once as a wrong strobe on the same beat. An index that skips or repeats moves the closing mask onto the wrong beat, and it also changes the number of beats before `done`. A stale busy flag shows up as `hdr_ready` staying low on the cycle after `done`, or as beats being passed while no payload is active. A wrong byte accumulator shows up only at `done`, as a wrong `byte_count`. The bench therefore sweeps every legal mask pair over short lengths under random stalls on both sides, so that each of these faults is seen within one payload.

// File: rtl/wstrb_pkg.sv
// Shared types and helpers for the payload write strobe expander.
// Assumes a 32-bit doubleword made of four byte lanes.
package wstrb_pkg;
    localparam int LANES = 4;

    typedef logic [LANES-1:0] lane_mask_t;

    // Position of a beat inside its payload; selects the strobe source.
    typedef enum logic [1:0] {
        POS_OPEN  = 2'd0,
        POS_INNER = 2'd1,
        POS_CLOSE = 2'd2
    } beat_pos_e;

    // Number of enabled lanes in a mask.
    function automatic logic [2:0] lane_count(lane_mask_t m);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) n = n + {2'b00, m[i]};
        return n;
    endfunction
endpackage

// File: rtl/wstrb_hdr_capture.sv
// Header capture: checks a header offered while idle, and latches it if it is legal.
// Assumes that hdr_load is a single-cycle strobe and that idle comes from the beat sequencer.
module wstrb_hdr_capture
    import wstrb_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             hdr_load,
    input  lane_mask_t       first_mask,
    input  lane_mask_t       last_mask,
    input  logic [LEN_W-1:0] len_dw,
    output logic             start,
    output logic             hdr_err,
    output lane_mask_t       first_q,
    output lane_mask_t       last_q,
    output logic [LEN_W-1:0] len_q
);
    logic offered;
    logic illegal;

    // Classify the offered header.
    always_comb begin
        offered = hdr_load && idle;
        illegal = (first_mask == '0) || (len_dw == '0);
        start   = offered && !illegal;
    end

    // Latch a legal header and flag an illegal one for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_err <= 1'b0;
            first_q <= '0;
            last_q  <= '0;
            len_q   <= '0;
        end else begin
            hdr_err <= offered && illegal;
            if (start) begin
                first_q <= first_mask;
                last_q  <= last_mask;
                len_q   <= len_dw;
            end
        end
    end
endmodule

// File: rtl/wstrb_beat_seq.sv
// Beat sequencer: tracks whether a payload is active, counts doublewords, and picks the strobe.
// Assumes that start and fire never coincide: start needs idle, fire needs active.
module wstrb_beat_seq
    import wstrb_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fire,
    input  lane_mask_t       first_q,
    input  lane_mask_t       last_q,
    input  logic [LEN_W-1:0] len_q,
    output logic             active,
    output logic             is_last,
    output logic [LEN_W-1:0] idx,
    output lane_mask_t       strb
);
    beat_pos_e pos;

    // Work out where the current beat sits and which mask applies.
    always_comb begin
        is_last = (idx == len_q - LEN_W'(1));
        if (idx == '0)    pos = POS_OPEN;
        else if (is_last) pos = POS_CLOSE;
        else              pos = POS_INNER;
        case (pos)
            POS_OPEN:  strb = first_q;
            POS_CLOSE: strb = last_q;
            default:   strb = '1;
        endcase
    end

    // Advance the beat index on each handoff, and drop to idle after the closing beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (fire) begin
            if (is_last) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/wstrb_byte_tally.sv
// Byte tally: adds up the enabled lanes of every beat handed off in a payload.
// Assumes that CNT_W is wide enough for LANES times the largest length.
module wstrb_byte_tally
    import wstrb_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             fire,
    input  lane_mask_t       strb,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] acc_q;

    // Running total that includes the beat on offer.
    always_comb total = acc_q + CNT_W'(lane_count(strb));

    // Clear at header acceptance, and fold in each beat that is handed off.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (start) acc_q <= '0;
        else if (fire)  acc_q <= total;
    end
endmodule

// File: rtl/wstrb_expander.sv
// Top of the payload write strobe expander.
// Passes payload beats straight through while a header is active, and adds the strobe,
// the doubleword index and the byte tally. There is no storage on the data path.
module wstrb_expander
    import wstrb_pkg::*;
#(
    parameter int LEN_W = 4,
    localparam int CNT_W = LEN_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_load,
    input  logic [3:0]       hdr_first_mask,
    input  logic [3:0]       hdr_last_mask,
    input  logic [LEN_W-1:0] hdr_len_dw,
    output logic             hdr_ready,
    output logic             hdr_err,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [31:0]      in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [31:0]      out_data,
    output logic [3:0]       out_strb,
    output logic [LEN_W-1:0] out_dw_idx,
    output logic [CNT_W-1:0] byte_count,
    output logic             done
);
    logic             start;
    logic             active;
    logic             is_last;
    logic             fire;
    lane_mask_t       first_q;
    lane_mask_t       last_q;
    logic [LEN_W-1:0] len_q;

    wstrb_hdr_capture #(.LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .idle(!active), .hdr_load(hdr_load),
        .first_mask(hdr_first_mask), .last_mask(hdr_last_mask), .len_dw(hdr_len_dw),
        .start(start), .hdr_err(hdr_err), .first_q(first_q), .last_q(last_q), .len_q(len_q)
    );

    wstrb_beat_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .fire(fire),
        .first_q(first_q), .last_q(last_q), .len_q(len_q),
        .active(active), .is_last(is_last), .idx(out_dw_idx), .strb(out_strb)
    );

    wstrb_byte_tally #(.CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .start(start), .fire(fire),
        .strb(out_strb), .total(byte_count)
    );

    // Stream gating: beats move only while a payload is active.
    always_comb begin
        hdr_ready = !active;
        out_valid = active && in_valid;
        in_ready  = active && out_ready;
        out_data  = in_data;
        fire      = out_valid && out_ready;
        done      = fire && is_last;
    end
endmodule

// File: rtl/wstrb_expander_chk.sv
// Checker for the strobe expander. It relates handshake, index, strobe and
// header-side ports over time. It is bound into every instance of the top.
module wstrb_expander_chk #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_ready,
    input logic             hdr_err,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [3:0]       out_strb,
    input logic [LEN_W-1:0] out_dw_idx,
    input logic [LEN_W-1:0] len_q,
    input logic             done
);
    a_r6_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> (!in_ready && !out_valid));

    a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_ready && !(out_valid && out_ready)) |=> $stable(out_dw_idx));

    a_r7_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !done) |=> (out_dw_idx == $past(out_dw_idx) + LEN_W'(1)));

    a_r4_inner_full: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dw_idx != '0 && out_dw_idx != len_q - LEN_W'(1)) |-> (out_strb == 4'hF));

    a_r2_open_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dw_idx == '0) |-> (out_strb != 4'h0));

    a_r9_done_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_ready && out_dw_idx == len_q - LEN_W'(1)));

    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> hdr_ready);

    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> hdr_ready);
endmodule

bind wstrb_expander wstrb_expander_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hdr_ready(hdr_ready), .hdr_err(hdr_err),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_strb(out_strb), .out_dw_idx(out_dw_idx), .len_q(len_q), .done(done)
);

// File: tb/wstrb_expander_bench.sv
module wstrb_expander_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 4;
    localparam int CNT_W = LEN_W + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hdr_load = 1'b0;
    logic [3:0]       hdr_first_mask = '0;
    logic [3:0]       hdr_last_mask = '0;
    logic [LEN_W-1:0] hdr_len_dw = '0;
    logic             hdr_ready, hdr_err;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_data = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [31:0]      out_data;
    logic [3:0]       out_strb;
    logic [LEN_W-1:0] out_dw_idx;
    logic [CNT_W-1:0] byte_count;
    logic             done;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [15:0] rnd = 16'hACE1;

    wstrb_expander #(.LEN_W(LEN_W)) u_wstrb_expander (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [3:0] m);
        return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
    endfunction

    task automatic step_rnd();
        rnd = {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
    endtask

    // One full payload under random stalls. A conflicting header is held on hdr_load throughout.
    task automatic run_payload(input logic [3:0] fm, input logic [3:0] lm, input int len);
        int k;
        int sum;
        logic [3:0] exp_s;
        @(negedge clk);
        check("R8 ready before load", 32'(hdr_ready), 32'd1);
        hdr_load = 1'b1; hdr_first_mask = fm; hdr_last_mask = lm; hdr_len_dw = LEN_W'(len);
        @(negedge clk);
        hdr_first_mask = ~fm; hdr_last_mask = 4'h5; hdr_len_dw = LEN_W'(1);
        k = 0; sum = 0;
        while (k < len) begin
            step_rnd();
            in_valid = rnd[0] | rnd[3];
            out_ready = rnd[1] | rnd[5];
            in_data = {8'(k), 8'(len), 4'(fm), 4'(lm), 8'hA5};
            #1;
            check("R8 busy", 32'(hdr_ready), 32'd0);
            check("R6 in_ready", 32'(in_ready), 32'(out_ready));
            check("R6 out_valid", 32'(out_valid), 32'(in_valid));
            if (in_valid && out_ready) begin
                if (k == 0) exp_s = fm;
                else if (k == len - 1) exp_s = lm;
                else exp_s = 4'hF;
                sum = sum + popc(exp_s);
                if (k == 0) check(len == 1 ? "R5 single strobe" : "R2 open strobe", 32'(out_strb), 32'(exp_s));
                else if (k == len - 1) check("R3 close strobe", 32'(out_strb), 32'(exp_s));
                else check("R4 inner strobe", 32'(out_strb), 32'(exp_s));
                check("R7 index", 32'(out_dw_idx), 32'(k));
                check("R6 data", out_data, in_data);
                check("R9 done", 32'(done), 32'(k == len - 1));
                if (k == len - 1) check("R9 byte_count", 32'(byte_count), 32'(sum));
                k = k + 1;
            end else begin
                check("R9 no done on stall", 32'(done), 32'd0);
            end
            @(negedge clk);
        end
        hdr_load = 1'b0;
        in_valid = 1'b1; out_ready = 1'b1;
        #1;
        check("R8 idle after close", 32'(hdr_ready), 32'd1);
        check("R6 idle out_valid", 32'(out_valid), 32'd0);
        check("R6 idle in_ready", 32'(in_ready), 32'd0);
        in_valid = 1'b0; out_ready = 1'b0;
    endtask

    // Illegal header: must be dropped with a one-cycle error pulse.
    task automatic run_bad(input logic [3:0] fm, input int len);
        @(negedge clk);
        hdr_load = 1'b1; hdr_first_mask = fm; hdr_last_mask = 4'hF; hdr_len_dw = LEN_W'(len);
        @(negedge clk);
        hdr_load = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
        #1;
        check("R10 err pulse", 32'(hdr_err), 32'd1);
        check("R10 stays idle", 32'(hdr_ready), 32'd1);
        check("R10 no beat", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R10 err clears", 32'(hdr_err), 32'd0);
        in_valid = 1'b0; out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        in_valid = 1'b1; out_ready = 1'b1;
        #1;
        check("R1 hdr_ready", 32'(hdr_ready), 32'd1);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 hdr_err", 32'(hdr_err), 32'd0);
        in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int len = 1; len <= 5; len++)
            for (int fm = 1; fm < 16; fm++)
                for (int lm = 0; lm < 16; lm++)
                    run_payload(4'(fm), 4'(lm), len);
        run_payload(4'h1, 4'h8, 15);
        run_payload(4'h8, 4'h1, 15);

        run_bad(4'h0, 3);
        run_bad(4'h0, 1);
        run_bad(4'hF, 0);
        run_payload(4'h6, 4'h3, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule